// File: doc/BRIEF.md
# Diminished-1 Modulo 2^n+1 Adder

This block adds two residues modulo 2^n+1 in one combinational pass. Each operand is held in diminished-1 form. A non-zero value X is carried as X-1 in an n-bit number field. A separate flag bit marks the value zero; when that flag is set, the number field carries no meaning. The result uses the same form.

The addition path works on 4-bit blocks. Each block reduces its bit generate and propagate signals to a group pair, and also forms two candidate sums: one for an incoming carry of 0 and one for 1. A parallel-prefix network runs over the block pairs. Its inverted carry-out is fed back as the end-around carry, which yields one carry for each block. That carry picks the block's sum.

A bypass multiplexer sits in front of the output. Its select has four named states, decoded from the two zero flags:
- `SEL_ADD`: both flags are clear, so the adder result is used.
- `SEL_PASS_A`: only B is zero, so A is forwarded.
- `SEL_PASS_B`: only A is zero, so B is forwarded.
- `SEL_ZERO`: both operands are zero, so the output is zero.

The select holds no state. It is re-decoded from the two flags on every input change.

Top module: `dm1_mod_adder`

## Requirements
- R1: A non-zero value X is represented as number field X-1 with zero flag 0. A zero flag of 1 represents the value zero, whatever the number field holds. Outputs follow the same encoding.
- R2: When both flags are 0 and A*+B* < 2^n-1, the output is number A*+B*+1 with zero flag 0.
- R3: When both flags are 0 and A*+B* >= 2^n, the output is number (A*+B*) mod 2^n with zero flag 0.
- R4: When both flags are 0 and A*+B* = 2^n-1, the output zero flag is 1 and the number field is all zeros.
- R5: When only A's flag is 1, the output number equals b_num and the output zero flag is 0.
- R6: When only B's flag is 1, the output number equals a_num and the output zero flag is 0.
- R7: When both flags are 1, the output zero flag is 1 and the number field is all zeros.
- R8: The number field of an operand whose zero flag is 1 has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_num | input | N | Diminished-1 number field of operand A |
| a_zero | input | 1 | Operand A is zero |
| b_num | input | N | Diminished-1 number field of operand B |
| b_zero | input | 1 | Operand B is zero |
| s_num | output | N | Diminished-1 number field of the result |
| s_zero | output | 1 | Result is zero |

## Verification
Immediate assertions check the adder path against an (n+1)-bit sum of the number fields, whenever the inputs are known. They cover the three add cases: increment, wrap, and all-propagate. They also cover the three bypass routes. The insensitivity to a masked number field (R8) cannot be seen in a single evaluation. The bench shows it by applying random garbage in masked fields and comparing every result with a reference computed from the decoded values modulo 2^n+1.

// File: rtl/dm1_pkg.sv
package dm1_pkg;

    localparam int BLK = 4;

    typedef enum logic [1:0] {
        SEL_ADD    = 2'd0,
        SEL_PASS_A = 2'd1,
        SEL_PASS_B = 2'd2,
        SEL_ZERO   = 2'd3
    } dm1_sel_e;

endpackage

// File: rtl/dm1_block.sv
module dm1_block
    import dm1_pkg::*;
(
    input  logic [BLK-1:0] p_in,
    input  logic [BLK-1:0] g_in,
    input  logic           cin,
    output logic [BLK-1:0] sum_out,
    output logic           grp_g,
    output logic           grp_p
);
    logic [BLK:0]   c_lo;
    logic [BLK:0]   c_hi;
    logic [BLK-1:0] sum_lo;
    logic [BLK-1:0] sum_hi;
    logic [BLK:0]   gg;
    logic [BLK:0]   pp;

    assign c_lo[0] = 1'b0;
    assign c_hi[0] = 1'b1;
    assign gg[0]   = 1'b0;
    assign pp[0]   = 1'b1;

    for (genvar i = 0; i < BLK; i++) begin : g_bit
        assign c_lo[i+1]  = g_in[i] | (p_in[i] & c_lo[i]);
        assign c_hi[i+1]  = g_in[i] | (p_in[i] & c_hi[i]);
        assign sum_lo[i]  = p_in[i] ^ c_lo[i];
        assign sum_hi[i]  = p_in[i] ^ c_hi[i];
        assign gg[i+1]    = g_in[i] | (p_in[i] & gg[i]);
        assign pp[i+1]    = p_in[i] & pp[i];
    end

    assign grp_g   = gg[BLK];
    assign grp_p   = pp[BLK];
    assign sum_out = cin ? sum_hi : sum_lo;

    always_comb begin
        if (!$isunknown({p_in, g_in, cin})) begin
            assert_sel_R2: assert (sum_out == (p_in ^ {cin ? c_hi[BLK-1:1] : c_lo[BLK-1:1], cin}))
                else $error("R2 block select mismatch");
        end
    end

    logic unused_carry;
    assign unused_carry = ^{c_lo[BLK], c_hi[BLK]};
endmodule

// File: rtl/dm1_block_prefix.sv
module dm1_block_prefix #(
    parameter int NB = 4
) (
    input  logic [NB-1:0] blk_g,
    input  logic [NB-1:0] blk_p,
    output logic [NB-1:0] blk_cin,
    output logic          all_prop
);
    localparam int LV = (NB > 1) ? $clog2(NB) : 1;

    logic [NB-1:0] gl [0:LV];
    logic [NB-1:0] pl [0:LV];
    logic          eac;

    assign gl[0] = blk_g;
    assign pl[0] = blk_p;

    for (genvar k = 0; k < LV; k++) begin : g_lvl
        localparam int D = 1 << k;
        for (genvar i = 0; i < NB; i++) begin : g_node
            if (i >= D) begin : g_op
                assign gl[k+1][i] = gl[k][i] | (pl[k][i] & gl[k][i-D]);
                assign pl[k+1][i] = pl[k][i] & pl[k][i-D];
            end else begin : g_pass
                assign gl[k+1][i] = gl[k][i];
                assign pl[k+1][i] = pl[k][i];
            end
        end
    end

    assign eac      = ~gl[LV][NB-1];
    assign all_prop = pl[LV][NB-1];
    assign blk_cin[0] = eac;

    for (genvar j = 1; j < NB; j++) begin : g_cin
        assign blk_cin[j] = gl[LV][j-1] | (pl[LV][j-1] & eac);
    end

    always_comb begin
        if (!$isunknown({blk_g, blk_p})) begin
            assert_allprop_cin_R4: assert (!all_prop || (&blk_cin))
                else $error("R4 all-propagate must carry into every block");
        end
    end
endmodule

// File: rtl/dm1_mod_adder.sv
module dm1_mod_adder
    import dm1_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] a_num,
    input  logic         a_zero,
    input  logic [N-1:0] b_num,
    input  logic         b_zero,
    output logic [N-1:0] s_num,
    output logic         s_zero
);
    localparam int NB = N / BLK;

    logic [N-1:0]  p_bit;
    logic [N-1:0]  g_bit;
    logic [N-1:0]  add_num;
    logic [NB-1:0] blk_g;
    logic [NB-1:0] blk_p;
    logic [NB-1:0] blk_cin;
    logic          all_prop;
    dm1_sel_e      sel;

    initial begin
        assert_width_R1: assert (N % BLK == 0 && N >= BLK)
            else $error("R1 width must be a multiple of the block size");
    end

    assign p_bit = a_num ^ b_num;
    assign g_bit = a_num & b_num;

    for (genvar j = 0; j < NB; j++) begin : g_blk
        dm1_block u_blk (
            .p_in    (p_bit[BLK*j +: BLK]),
            .g_in    (g_bit[BLK*j +: BLK]),
            .cin     (blk_cin[j]),
            .sum_out (add_num[BLK*j +: BLK]),
            .grp_g   (blk_g[j]),
            .grp_p   (blk_p[j])
        );
    end

    dm1_block_prefix #(.NB(NB)) u_pfx (
        .blk_g    (blk_g),
        .blk_p    (blk_p),
        .blk_cin  (blk_cin),
        .all_prop (all_prop)
    );

    always_comb begin
        unique case ({a_zero, b_zero})
            2'b00:   sel = SEL_ADD;
            2'b01:   sel = SEL_PASS_A;
            2'b10:   sel = SEL_PASS_B;
            default: sel = SEL_ZERO;
        endcase
    end

    always_comb begin
        unique case (sel)
            SEL_ADD: begin
                s_num  = all_prop ? '0 : add_num;
                s_zero = all_prop;
            end
            SEL_PASS_A: begin
                s_num  = a_num;
                s_zero = 1'b0;
            end
            SEL_PASS_B: begin
                s_num  = b_num;
                s_zero = 1'b0;
            end
            default: begin
                s_num  = '0;
                s_zero = 1'b1;
            end
        endcase
    end

    logic [N:0] ref_sum;
    assign ref_sum = {1'b0, a_num} + {1'b0, b_num};

    always_comb begin
        if (!$isunknown({a_num, b_num, a_zero, b_zero, s_num, s_zero})) begin
            if (!a_zero && !b_zero && ref_sum < (N+1)'((1 << N) - 1)) begin
                assert_inc_R2: assert (s_num == ref_sum[N-1:0] + 1'b1 && !s_zero)
                    else $error("R2 increment case wrong");
            end
            if (!a_zero && !b_zero && ref_sum[N]) begin
                assert_wrap_R3: assert (s_num == ref_sum[N-1:0] && !s_zero)
                    else $error("R3 wrap case wrong");
            end
            if (!a_zero && !b_zero && ref_sum == (N+1)'((1 << N) - 1)) begin
                assert_allprop_R4: assert (s_zero && s_num == '0)
                    else $error("R4 zero result not flagged");
            end
            if (a_zero && !b_zero) begin
                assert_pass_b_R5: assert (s_num == b_num && !s_zero)
                    else $error("R5 B not forwarded");
            end
            if (!a_zero && b_zero) begin
                assert_pass_a_R6: assert (s_num == a_num && !s_zero)
                    else $error("R6 A not forwarded");
            end
            if (a_zero && b_zero) begin
                assert_both_zero_R7: assert (s_zero && s_num == '0)
                    else $error("R7 zero plus zero wrong");
            end
        end
    end
endmodule

// File: tb/dm1_mod_adder_bench.sv
module dm1_mod_adder_bench;
    localparam int N      = 16;
    localparam int PERIOD = 10;
    localparam longint MODV = (64'd1 << N) + 1;

    logic         clk = 1'b0;
    logic [N-1:0] a_num, b_num, s_num;
    logic         a_zero, b_zero, s_zero;
    int           checks = 0;
    int           errors = 0;
    bit           done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    dm1_mod_adder #(.N(N)) u_dm1_mod_adder (
        .a_num (a_num), .a_zero (a_zero),
        .b_num (b_num), .b_zero (b_zero),
        .s_num (s_num), .s_zero (s_zero)
    );

    function automatic longint decode(logic [N-1:0] num, logic z);
        return z ? 0 : longint'(num) + 1;
    endfunction

    function automatic logic [N:0] expect_out(logic [N-1:0] an, logic az,
                                              logic [N-1:0] bn, logic bz);
        longint s;
        s = (decode(an, az) + decode(bn, bz)) % MODV;
        if (s == 0) return {1'b1, {N{1'b0}}};
        return {1'b0, N'(s - 1)};
    endfunction

    task automatic run(string tag, logic [N-1:0] an, logic az,
                       logic [N-1:0] bn, logic bz);
        logic [N:0] exp_v;
        @(posedge clk);
        a_num = an; a_zero = az; b_num = bn; b_zero = bz;
        exp_v = expect_out(an, az, bn, bz);
        @(negedge clk);
        checks++;
        if ({s_zero, s_num} !== exp_v) begin
            errors++;
            $display("FAIL %s a=%h/%b b=%h/%b actual=%b/%h expected=%b/%h",
                     tag, an, az, bn, bz, s_zero, s_num, exp_v[N], exp_v[N-1:0]);
        end
    endtask

    function automatic string classify(logic [N-1:0] an, logic az,
                                       logic [N-1:0] bn, logic bz);
        logic [N:0] s;
        if (az && bz) return "R7_R8";
        if (az) return "R5_R8";
        if (bz) return "R6_R8";
        s = {1'b0, an} + {1'b0, bn};
        if (s[N]) return "R3";
        if (s == (N+1)'((1 << N) - 1)) return "R4";
        return "R2";
    endfunction

    initial begin
        a_num = '0; b_num = '0; a_zero = 1'b1; b_zero = 1'b1;
        @(negedge clk);
        checks++;
        if (!(s_zero === 1'b1 && s_num === '0)) begin
            errors++;
            $display("FAIL R7 initial actual=%b/%h expected=1/0000", s_zero, s_num);
        end

        run("R2 smallest", 16'h0000, 0, 16'h0000, 0);
        run("R2 mid", 16'h1234, 0, 16'h0100, 0);
        run("R2 edge", 16'hFFFE, 0, 16'h0000, 0);
        run("R4 allprop", 16'hFFFF, 0, 16'h0000, 0);
        run("R4 split", 16'h8000, 0, 16'h7FFF, 0);
        run("R4 alternating", 16'hAAAA, 0, 16'h5555, 0);
        run("R3 just over", 16'hFFFF, 0, 16'h0001, 0);
        run("R3 largest", 16'hFFFF, 0, 16'hFFFF, 0);
        run("R3 block carry", 16'h0FFF, 0, 16'hF001, 0);
        run("R5 pass b", 16'h0000, 1, 16'hBEEF, 0);
        run("R6 pass a", 16'hCAFE, 0, 16'h0000, 1);
        run("R7 both zero", 16'h0000, 1, 16'h0000, 1);
        run("R8 masked a", 16'hFFFF, 1, 16'h0001, 0);
        run("R8 masked b", 16'h1357, 0, 16'h9ABC, 1);
        run("R8 masked both", 16'hDEAD, 1, 16'hBEEF, 1);
        run("R1 max value", 16'hFFFF, 0, 16'h0000, 1);

        void'($urandom(32'd1729));
        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] ra, rb;
            logic za, zb;
            ra = N'($urandom);
            rb = N'($urandom);
            za = ($urandom % 8) == 0;
            zb = ($urandom % 8) == 0;
            if ((i % 16) == 5) rb = ~ra;
            if ((i % 16) == 9) rb = N'(((1 << N) - 1) - ra + ($urandom % 3));
            run(classify(ra, za, rb, zb), ra, za, rb, zb);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule